// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block sits between the status logic of a UART and its host interface. It merges four interrupt sources into one interrupt line and an identification byte. The sources are line errors, received data, an empty transmit holding register and modem-line changes. Each source has its own enable bit. When several sources are active at once, the identification byte names the most urgent one. A host reads the byte, services the named source, and reads it again until no source is pending.

Reading some registers changes state. An identification read that reports the transmit-empty source clears that source. Reads of the line-status and modem-status registers are turned into one-cycle clear strobes, which go back to the logic that holds those flags. Each read strobe is edge-detected, so a strobe held high for several cycles has its side effect applied once.

All outputs are registered. They reflect the inputs and strobes of the previous clock cycle.

Top module: `uart_int_ident`

## Requirements
- R1: While reset is high, and in the first cycle after it, `irq` is 0, `id_val` is 8'h01, and `line_clr` and `modem_clr` are 0.
- R2: `int_en` bit 0 enables received data, bit 1 enables transmit-holding-empty, bit 2 enables line status and bit 3 enables modem status. An active source whose bit is 0 never appears in `id_val` and never raises `irq`.
- R3: `id_val` bit 0 is 0 when an interrupt is pending and 1 when none is pending. Bits 2:1 name the source: 11 line status, 10 received data, 01 transmit holding empty, 00 modem status. Bits 7:3 are 0. With nothing pending, bits 2:1 are 00. `irq` always equals the inverse of `id_val` bit 0.
- R4: Priority runs from line status (highest), through received data and transmit holding empty, to modem status (lowest).
- R5: The received-data condition is `rx_trig` when `fifo_mode` is 1 and `rx_avail` when `fifo_mode` is 0.
- R6: The line-status source is active when any bit of `line_err` is 1 (bit 0 overrun, bit 1 parity, bit 2 framing, bit 3 break). The modem source is active when any bit of `modem_delta` is 1.
- R7: The transmit-empty source arms in the cycle after `tx_empty` rises. It drops whenever `tx_empty` is 0.
- R8: A rising edge of `id_rd`, seen while `id_val` reports transmit holding empty, clears that source. An identification read that reports any other source leaves it pending.
- R9: A rising edge of `hold_wr` clears a pending transmit-empty source, unless `tx_empty` rises in the same cycle.
- R10: A read strobe held high for several cycles counts as one read. It gives one clear pulse and at most one transmit-empty clear.
- R11: `line_clr` (or `modem_clr`) is high for exactly the one cycle after the first cycle in which `line_rd` (or `modem_rd`) is high.
- R12: `irq` and `id_val` follow the inputs with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_en | input | 4 | Source enables (bit 0 rx, 1 tx-empty, 2 line, 3 modem) |
| fifo_mode | input | 1 | Selects the trigger-level condition for received data |
| rx_avail | input | 1 | At least one received character is waiting |
| rx_trig | input | 1 | Receive trigger level or timeout reached |
| tx_empty | input | 1 | Transmit holding register is empty |
| line_err | input | 4 | Overrun, parity, framing, break flags |
| modem_delta | input | 4 | Modem-line change flags |
| id_rd | input | 1 | Host reads the identification register |
| hold_wr | input | 1 | Host writes the transmit holding register |
| line_rd | input | 1 | Host reads the line status register |
| modem_rd | input | 1 | Host reads the modem status register |
| irq | output | 1 | Interrupt request, active high |
| id_val | output | 8 | Identification byte |
| line_clr | output | 1 | Clear strobe to the line-error flags |
| modem_clr | output | 1 | Clear strobe to the modem change flags |

## Verification
Assertions check on every cycle that `irq` and `id_val` bit 0 agree, and that an idle byte carries no source code. They also check that an active, enabled line error always wins, and that the clear strobes last one cycle. For the transmit-empty source they check that an identification read or a holding write clears it, and that it is never pending without an empty register. Only the bench scenarios show the full priority order and the masking by each enable bit. They also show the receive-condition selection, re-arming after a refill, and the fact that reads reporting other sources leave the transmit-empty source pending.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;
  typedef enum logic [1:0] {
    SRC_MODEM  = 2'b00,
    SRC_THRE   = 2'b01,
    SRC_RXDATA = 2'b10,
    SRC_LINE   = 2'b11
  } src_code_t;

  localparam int EN_RX    = 0;
  localparam int EN_THRE  = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;
  localparam int EN_W     = 4;
endpackage

// File: rtl/uart_iid_edge.sv
module uart_iid_edge #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] lvl_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) lvl_q[g] <= 1'b0;
      else     lvl_q[g] <= lvl[g];
    end
    assign rise[g] = lvl[g] & ~lvl_q[g];
  end
endmodule

// File: rtl/uart_iid_thre.sv
module uart_iid_thre (
  input  logic clk,
  input  logic rst,
  input  logic tx_empty,
  input  logic hold_wr,
  input  logic id_read,
  input  logic shown_thre,
  output logic pend_nxt,
  output logic pend
);
  logic tx_q;
  logic arm;
  logic drop;

  assign arm      = tx_empty & ~tx_q;
  assign drop     = hold_wr | (id_read & shown_thre);
  assign pend_nxt = tx_empty & (arm | (pend & ~drop));

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q <= 1'b0;
      pend <= 1'b0;
    end else begin
      tx_q <= tx_empty;
      pend <= pend_nxt;
    end
  end

  AST_THRE_ID_CLR: assert property (@(posedge clk) disable iff (rst)
    (id_read && shown_thre) |=> !pend); // R8
  AST_THRE_WR_CLR: assert property (@(posedge clk) disable iff (rst)
    (hold_wr && pend) |=> !pend); // R9
  AST_THRE_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (rst)
    pend |-> $past(tx_empty)); // R7
endmodule

// File: rtl/uart_iid_prio.sv
module uart_iid_prio
  import uart_iid_pkg::*;
#(
  parameter int LSR_W = 4,
  parameter int MSR_W = 4
) (
  input  logic [EN_W-1:0]  en,
  input  logic [LSR_W-1:0] line_err,
  input  logic             rx_cond,
  input  logic             thre,
  input  logic [MSR_W-1:0] modem_delta,
  output logic             any,
  output src_code_t        code
);
  logic line_hit, rx_hit, thre_hit, modem_hit;

  assign line_hit  = en[EN_LINE]  & (|line_err);
  assign rx_hit    = en[EN_RX]    & rx_cond;
  assign thre_hit  = en[EN_THRE]  & thre;
  assign modem_hit = en[EN_MODEM] & (|modem_delta);

  always_comb begin
    any  = 1'b1;
    code = SRC_MODEM;
    if (line_hit)       code = SRC_LINE;
    else if (rx_hit)    code = SRC_RXDATA;
    else if (thre_hit)  code = SRC_THRE;
    else if (modem_hit) code = SRC_MODEM;
    else                any  = 1'b0;
  end
endmodule

// File: rtl/uart_int_ident.sv
module uart_int_ident
  import uart_iid_pkg::*;
#(
  parameter int LSR_W = 4,
  parameter int MSR_W = 4,
  parameter int ID_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       int_en,
  input  logic             fifo_mode,
  input  logic             rx_avail,
  input  logic             rx_trig,
  input  logic             tx_empty,
  input  logic [LSR_W-1:0] line_err,
  input  logic [MSR_W-1:0] modem_delta,
  input  logic             id_rd,
  input  logic             hold_wr,
  input  logic             line_rd,
  input  logic             modem_rd,
  output logic             irq,
  output logic [ID_W-1:0]  id_val,
  output logic             line_clr,
  output logic             modem_clr
);
  localparam int NRD   = 4;
  localparam int RD_ID = 0;
  localparam int RD_WR = 1;
  localparam int RD_LS = 2;
  localparam int RD_MS = 3;

  logic [NRD-1:0] rd_lvl, rd_rise;
  logic           rx_cond;
  logic           thre_nxt, thre_q;
  logic           shown_thre;
  logic           any;
  src_code_t      code;
  logic [ID_W-1:0] id_nxt;

  assign rd_lvl = {modem_rd, line_rd, hold_wr, id_rd};

  uart_iid_edge #(.N(NRD)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (rd_lvl),
    .rise (rd_rise)
  );

  assign shown_thre = (id_val[2:0] == {SRC_THRE, 1'b0});

  uart_iid_thre u_thre (
    .clk        (clk),
    .rst        (rst),
    .tx_empty   (tx_empty),
    .hold_wr    (rd_rise[RD_WR]),
    .id_read    (rd_rise[RD_ID]),
    .shown_thre (shown_thre),
    .pend_nxt   (thre_nxt),
    .pend       (thre_q)
  );

  assign rx_cond = fifo_mode ? rx_trig : rx_avail;

  uart_iid_prio #(.LSR_W(LSR_W), .MSR_W(MSR_W)) u_prio (
    .en          (int_en),
    .line_err    (line_err),
    .rx_cond     (rx_cond),
    .thre        (thre_nxt),
    .modem_delta (modem_delta),
    .any         (any),
    .code        (code)
  );

  always_comb begin
    id_nxt      = '0;
    id_nxt[0]   = ~any;
    id_nxt[2:1] = code;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      id_val    <= {{(ID_W-1){1'b0}}, 1'b1};
      irq       <= 1'b0;
      line_clr  <= 1'b0;
      modem_clr <= 1'b0;
    end else begin
      id_val    <= id_nxt;
      irq       <= any;
      line_clr  <= rd_rise[RD_LS];
      modem_clr <= rd_rise[RD_MS];
    end
  end

  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    irq == !id_val[0]); // R3
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (rst)
    id_val[0] |-> (id_val[ID_W-1:1] == '0)); // R3
  AST_LINE_FIRST: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(int_en[EN_LINE] && (|line_err))) |-> (id_val[2:0] == 3'b110)); // R4
  AST_LCLR_PULSE: assert property (@(posedge clk) disable iff (rst)
    line_clr |=> !line_clr); // R10
  AST_MCLR_PULSE: assert property (@(posedge clk) disable iff (rst)
    modem_clr |=> !modem_clr); // R11
  AST_THRE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !thre_q |-> (id_val[2:0] != 3'b010)); // R7
endmodule

// File: tb/test_uart_int_ident.sv
module test_uart_int_ident;
  logic clk = 0;
  logic rst = 1;
  logic [3:0] int_en = 0;
  logic fifo_mode = 0, rx_avail = 0, rx_trig = 0, tx_empty = 0;
  logic [3:0] line_err = 0, modem_delta = 0;
  logic id_rd = 0, hold_wr = 0, line_rd = 0, modem_rd = 0;
  logic irq, line_clr, modem_clr;
  logic [7:0] id_val;

  int errors = 0, checks = 0;
  bit done = 0;
  string cur_req = "R12";

  always #2 clk = ~clk;

  uart_int_ident i_uart_int_ident (
    .clk(clk), .rst(rst), .int_en(int_en), .fifo_mode(fifo_mode),
    .rx_avail(rx_avail), .rx_trig(rx_trig), .tx_empty(tx_empty),
    .line_err(line_err), .modem_delta(modem_delta), .id_rd(id_rd),
    .hold_wr(hold_wr), .line_rd(line_rd), .modem_rd(modem_rd),
    .irq(irq), .id_val(id_val), .line_clr(line_clr), .modem_clr(modem_clr)
  );

  // behavioural reference
  logic [7:0] m_id; logic m_irq, m_lc, m_mc, m_thre, m_txq, m_rdq, m_wrq, m_lrq, m_mrq;
  always @(posedge clk) begin
    logic rxc, rd_e, wr_e;
    if (rst) begin
      m_id = 8'h01; m_irq = 0; m_lc = 0; m_mc = 0; m_thre = 0;
      m_txq = 0; m_rdq = 0; m_wrq = 0; m_lrq = 0; m_mrq = 0;
    end else begin
      rd_e = id_rd && !m_rdq;
      wr_e = hold_wr && !m_wrq;
      if (!tx_empty) m_thre = 0;
      else if (!m_txq) m_thre = 1;
      else if (wr_e) m_thre = 0;
      else if (rd_e && m_id[2:0] == 3'b010) m_thre = 0;
      rxc = fifo_mode ? rx_trig : rx_avail;
      if (int_en[2] && line_err != 0)        m_id = 8'h06;
      else if (int_en[0] && rxc)             m_id = 8'h04;
      else if (int_en[1] && m_thre)          m_id = 8'h02;
      else if (int_en[3] && modem_delta != 0) m_id = 8'h00;
      else                                   m_id = 8'h01;
      m_irq = !m_id[0];
      m_lc = line_rd && !m_lrq;
      m_mc = modem_rd && !m_mrq;
      m_rdq = id_rd; m_wrq = hold_wr; m_lrq = line_rd; m_mrq = modem_rd; m_txq = tx_empty;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if ({irq, id_val, line_clr, modem_clr} !== {m_irq, m_id, m_lc, m_mc}) begin
        errors++;
        $display("FAIL %s per-cycle: actual irq=%b id=%h lc=%b mc=%b expected irq=%b id=%h lc=%b mc=%b",
                 cur_req, irq, id_val, line_clr, modem_clr, m_irq, m_id, m_lc, m_mc);
      end
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic exp_id(input logic [7:0] e, input string req);
    checks++;
    if (id_val !== e || irq !== !e[0]) begin
      errors++;
      $display("FAIL %s: actual id=%h irq=%b expected id=%h irq=%b", req, id_val, irq, e, !e[0]);
    end
  endtask

  task automatic exp_bit(input logic a, input logic e, input string req);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, a, e);
    end
  endtask

  initial begin
    tick(3);
    exp_id(8'h01, "R1 in reset"); exp_bit(line_clr, 0, "R1 line_clr"); exp_bit(modem_clr, 0, "R1 modem_clr");
    rst = 0; tick();
    exp_id(8'h01, "R1 after reset");

    // R2: all sources active, nothing enabled
    line_err = 4'b0001; rx_avail = 1; modem_delta = 4'b0010; tx_empty = 1; tick(2);
    exp_id(8'h01, "R2 all masked");
    int_en = 4'b1011; tick();
    exp_id(8'h04, "R2 line masked");
    int_en = 4'b0111; rx_avail = 0; tick();
    exp_id(8'h06, "R2 modem masked, line shows");

    // R4 priority ladder
    cur_req = "R4";
    int_en = 4'hF; rx_avail = 1; tick();
    exp_id(8'h06, "R4 line over all");
    line_err = 0; tick();
    exp_id(8'h04, "R4 rx over thre");
    rx_avail = 0; tick();
    exp_id(8'h02, "R4 thre over modem");

    // R8/R10: held id read clears thre once
    cur_req = "R8";
    id_rd = 1; tick();
    exp_id(8'h00, "R8 id read clears thre");
    tick(2); id_rd = 0; tick();
    exp_id(8'h00, "R10 held id read single");

    // R7 re-arm
    cur_req = "R7";
    tx_empty = 0; tick(); tx_empty = 1; tick();
    exp_id(8'h02, "R7 rearm after refill");
    tx_empty = 0; tick();
    exp_id(8'h00, "R7 drops when not empty");
    tx_empty = 1; tick();

    // R8 negative: read reports line, thre stays
    cur_req = "R8";
    line_err = 4'b1000; tick();
    exp_id(8'h06, "R6 break bit");
    id_rd = 1; tick(); id_rd = 0; line_err = 0; tick();
    exp_id(8'h02, "R8 other-source read keeps thre");

    // R9 write clears
    cur_req = "R9";
    hold_wr = 1; tick(); hold_wr = 0;
    exp_id(8'h00, "R9 holding write clears thre");
    modem_delta = 0; tick();
    exp_id(8'h01, "R3 idle after all cleared");

    // R5 receive condition selection
    cur_req = "R5";
    fifo_mode = 1; rx_avail = 1; rx_trig = 0; tick();
    exp_id(8'h01, "R5 fifo mode ignores avail");
    rx_trig = 1; tick();
    exp_id(8'h04, "R5 fifo mode uses trigger");
    fifo_mode = 0; rx_avail = 0; tick();
    exp_id(8'h01, "R5 plain mode ignores trigger");
    rx_trig = 0;

    // R6 each error bit
    cur_req = "R6";
    for (int b = 0; b < 4; b++) begin
      line_err = 4'b0001 << b; tick();
      exp_id(8'h06, "R6 error bit");
    end
    line_err = 0; tick();

    // R11 / R10 clear strobes
    cur_req = "R11";
    line_rd = 1; tick();
    exp_bit(line_clr, 1, "R11 line_clr pulse");
    tick();
    exp_bit(line_clr, 0, "R10 line_clr single for held read");
    tick(2); line_rd = 0;
    modem_rd = 1; tick();
    exp_bit(modem_clr, 1, "R11 modem_clr pulse");
    modem_rd = 0; tick();
    exp_bit(modem_clr, 0, "R11 modem_clr ends");

    // R12 latency
    cur_req = "R12";
    modem_delta = 4'b0100;
    @(posedge clk); #1;
    exp_id(8'h00, "R12 one-cycle latency");
    tick();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule